// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block decides which operating mode a CAN protocol controller is in. Software writes a 3-bit mode request. The block applies that request only when the protocol engine allows it, and it reports the mode actually in effect on a 3-bit status output. The protocol engine gives it three inputs: a transmit-pending flag, a busy flag (a frame is being sent or received), and the receive line sampled once per bit time through a strobe. From these the block decides when a change is safe. Bit timing, framing, arbitration, error counting and acceptance filtering live elsewhere.

The block produces the per-mode enables for transmit, receive and acknowledge, and it drives the transmit pin. It raises a lock signal that opens the protected configuration registers to writes. It pulses a clear to the error counters whenever configuration mode is entered. It also runs a bus-activity wake detector for sleep. On a bus wake the block restores the mode that was active before sleep, drops the frame that caused the wake, and does not go back to sleep until software changes the request.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the status is configuration (100), `cfg_lock` is 1, `ecnt_clr` is 0 and `wake_flag` is 0.
- R2: Request codes decode as follows: 000 is normal (status 000), or error recognition (status 111) when `errrec_req` is 1; 001 is sleep (001); 010 is loopback (010); 011 is listen-only (011); any code with bit 2 set is configuration (100). An allowed change shows on the status one clock after the request.
- R3: While `tx_pending` is 1, no requested change takes effect and the status keeps the old mode.
- R4: Configuration is not entered while `busy` is 1.
- R5: In configuration mode `cfg_lock` is 1, transmit and receive enables are 0, and `ecnt_clr` pulses for exactly one cycle on entry. `wake_flag` is not altered by the mode change. `cfg_lock` is 0 in every other mode.
- R6: A sleep request made while `busy` is 1 takes effect only after 11 consecutive recessive bits have been sampled on `bit_strobe`. A dominant sample restarts the count. A sleep request made while `busy` is 0 takes effect at once.
- R7: In sleep, `tx_pin` is 1 and the transmit and receive enables are 0.
- R8: In sleep with `wake_en` set, a 1-to-0 change on `rx_pin` does two things at the same edge: it sets `wake_flag`, and it returns the status to the mode held before sleep. With `wake_en` clear, nothing happens. `wake_irq` equals `wake_flag` AND `wake_ie`.
- R9: After a bus wake, `rx_en` stays 0 until 11 consecutive recessive bits have been counted from the wake. A standing sleep request is not acted on again until the request changes.
- R10: Only in normal mode does `tx_pin` follow `tx_bit`. `ack_en` is 1 only in normal mode.
- R11: In listen-only and error recognition, `tx_en` and `ack_en` are 0, `tx_pin` is 1 and `rx_en` is 1.
- R12: In loopback, `rx_core` follows `tx_bit`, `tx_pin` stays 1, and `tx_en` and `rx_en` are 1.
- R13: `wake_clr` clears `wake_flag` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_mode | input | 3 | Requested mode code |
| errrec_req | input | 1 | With code 000, selects error recognition |
| tx_pending | input | 1 | A transmission is still queued |
| busy | input | 1 | A frame is being sent or received |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| rx_pin | input | 1 | Receive line, 1 is recessive |
| tx_bit | input | 1 | Transmit bit from the protocol engine |
| wake_en | input | 1 | Enables bus-activity wake detection |
| wake_ie | input | 1 | Enables the wake interrupt |
| wake_clr | input | 1 | Clears the wake flag |
| mode_status | output | 3 | Mode in effect |
| cfg_lock | output | 1 | Opens the protected configuration registers |
| ecnt_clr | output | 1 | One-cycle error-counter clear |
| wake_flag | output | 1 | Sticky wake flag |
| wake_irq | output | 1 | Wake interrupt |
| tx_pin | output | 1 | Transmit pin |
| rx_core | output | 1 | Receive bit delivered to the protocol engine |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| ack_en | output | 1 | Acknowledge and error-frame enable |

## Verification
If the mode register holds a wrong value, it shows one clock later on `mode_status` and on the enable and pin outputs derived from it. A wrong idle count does not show until the next sleep request or bus wake. There it moves the sleep entry edge, or the release of `rx_en`, away from the twelfth edge after the count restarts. A lost or corrupted copy of the pre-sleep mode shows only at a bus wake, as a wrong restored status. The bench therefore drives each of these through a full sleep-and-wake round trip from two different starting modes.

// File: rtl/canmode_pkg.sv
`timescale 1ns/1ps
package canmode_pkg;

   typedef enum logic [2:0] {
      MODE_NORMAL = 3'b000,
      MODE_SLEEP  = 3'b001,
      MODE_LOOP   = 3'b010,
      MODE_LISTEN = 3'b011,
      MODE_CONFIG = 3'b100,
      MODE_ERRREC = 3'b111
   } opmode_e;

   // Request decode: bit 2 wins, then the low pair picks the mode.
   function automatic opmode_e decode_req(input logic [2:0] code, input logic errrec);
      opmode_e m;
      if (code[2]) m = MODE_CONFIG;
      else begin
         case (code[1:0])
            2'b00:   m = errrec ? MODE_ERRREC : MODE_NORMAL;
            2'b01:   m = MODE_SLEEP;
            2'b10:   m = MODE_LOOP;
            default: m = MODE_LISTEN;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/can_idle_detect.sv
`timescale 1ns/1ps
module can_idle_detect #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_strobe,
   input  logic rx_bit,
   input  logic restart,
   output logic idle
);
   localparam int CW = $clog2(IDLE_BITS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

   generate
      if (IDLE_BITS < 2) begin : g_bad_limit
         $error("can_idle_detect: IDLE_BITS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= '0;
      else if (restart)      run_q <= '0;
      else if (bit_strobe) begin
         if (!rx_bit)             run_q <= '0;
         else if (run_q != LIMIT) run_q <= run_q + CW'(1);
      end
   end

   assign idle = (run_q == LIMIT);
endmodule

// File: rtl/can_wake_detect.sv
`timescale 1ns/1ps
module can_wake_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_pin,
   input  logic asleep,
   input  logic wake_en,
   input  logic wake_clr,
   output logic wake_evt,
   output logic wake_flag
);
   logic rx_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= 1'b1;
      else        rx_q <= rx_pin;
   end

   // recessive-to-dominant edge while asleep
   assign wake_evt = asleep & wake_en & rx_q & ~rx_pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wake_evt) flag_q <= 1'b1;
      else if (wake_clr) flag_q <= 1'b0;
   end

   assign wake_flag = flag_q;
endmodule

// File: rtl/can_mode_fsm.sv
`timescale 1ns/1ps
module can_mode_fsm
   import canmode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] req_mode,
   input  logic       errrec_req,
   input  logic       tx_pending,
   input  logic       busy,
   input  logic       idle,
   input  logic       wake_evt,
   output opmode_e    mode,
   output logic       ecnt_clr,
   output logic       discard
);
   opmode_e mode_q, prev_q, tgt, nxt;
   logic    hold_q, clr_q, disc_q;

   always_comb begin
      tgt = decode_req(req_mode, errrec_req);
      nxt = mode_q;
      if (mode_q == MODE_SLEEP && wake_evt) begin
         nxt = prev_q;
      end else if (tgt != mode_q && !tx_pending) begin
         case (tgt)
            MODE_CONFIG: if (!busy) nxt = tgt;
            MODE_SLEEP:  if (!hold_q && (!busy || idle)) nxt = tgt;
            default:     nxt = tgt;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_CONFIG;
         prev_q <= MODE_CONFIG;
         hold_q <= 1'b0;
         clr_q  <= 1'b0;
         disc_q <= 1'b0;
      end else begin
         mode_q <= nxt;
         if (nxt == MODE_SLEEP && mode_q != MODE_SLEEP) prev_q <= mode_q;
         if (wake_evt)                hold_q <= 1'b1;
         else if (tgt != MODE_SLEEP)  hold_q <= 1'b0;
         clr_q <= (nxt == MODE_CONFIG) && (mode_q != MODE_CONFIG);
         if (wake_evt)  disc_q <= 1'b1;
         else if (idle) disc_q <= 1'b0;
      end
   end

   assign mode     = mode_q;
   assign ecnt_clr = clr_q;
   assign discard  = disc_q;
endmodule

// File: rtl/can_mode_gate.sv
`timescale 1ns/1ps
module can_mode_gate
   import canmode_pkg::*;
(
   input  opmode_e mode,
   input  logic    discard,
   input  logic    tx_bit,
   input  logic    rx_pin,
   output logic    tx_drive,
   output logic    rx_core,
   output logic    tx_en,
   output logic    rx_en,
   output logic    ack_en,
   output logic    cfg_lock
);
   always_comb begin
      tx_en    = 1'b0;
      rx_en    = 1'b0;
      ack_en   = 1'b0;
      tx_drive = 1'b1;
      rx_core  = rx_pin;
      cfg_lock = 1'b0;
      case (mode)
         MODE_NORMAL: begin
            tx_en    = 1'b1;
            rx_en    = ~discard;
            ack_en   = 1'b1;
            tx_drive = tx_bit;
         end
         MODE_LISTEN, MODE_ERRREC: rx_en = ~discard;
         MODE_LOOP: begin
            tx_en   = 1'b1;
            rx_en   = ~discard;
            rx_core = tx_bit;
         end
         MODE_CONFIG: cfg_lock = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/can_mode_seq.sv
`timescale 1ns/1ps
module can_mode_seq
   import canmode_pkg::*;
#(
   parameter int IDLE_BITS = 11,
   parameter bit PIN_REG   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] req_mode,
   input  logic       errrec_req,
   input  logic       tx_pending,
   input  logic       busy,
   input  logic       bit_strobe,
   input  logic       rx_pin,
   input  logic       tx_bit,
   input  logic       wake_en,
   input  logic       wake_ie,
   input  logic       wake_clr,
   output logic [2:0] mode_status,
   output logic       cfg_lock,
   output logic       ecnt_clr,
   output logic       wake_flag,
   output logic       wake_irq,
   output logic       tx_pin,
   output logic       rx_core,
   output logic       tx_en,
   output logic       rx_en,
   output logic       ack_en
);
   opmode_e mode_w;
   logic    idle_w, wake_evt_w, discard_w, tx_drive_w;

   can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_pin),
      .restart(wake_evt_w), .idle(idle_w)
   );

   can_wake_detect u_wake (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin),
      .asleep(mode_w == MODE_SLEEP), .wake_en(wake_en), .wake_clr(wake_clr),
      .wake_evt(wake_evt_w), .wake_flag(wake_flag)
   );

   can_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .errrec_req(errrec_req),
      .tx_pending(tx_pending), .busy(busy), .idle(idle_w), .wake_evt(wake_evt_w),
      .mode(mode_w), .ecnt_clr(ecnt_clr), .discard(discard_w)
   );

   can_mode_gate u_gate (
      .mode(mode_w), .discard(discard_w), .tx_bit(tx_bit), .rx_pin(rx_pin),
      .tx_drive(tx_drive_w), .rx_core(rx_core), .tx_en(tx_en), .rx_en(rx_en),
      .ack_en(ack_en), .cfg_lock(cfg_lock)
   );

   generate
      if (PIN_REG) begin : g_pin_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b1;
            else        pin_q <= tx_drive_w;
         end
         assign tx_pin = pin_q;
      end else begin : g_pin_comb
         assign tx_pin = tx_drive_w;
      end
   endgenerate

   assign mode_status = mode_w;
   assign wake_irq    = wake_flag & wake_ie;
endmodule

// File: rtl/can_mode_seq_chk.sv
`timescale 1ns/1ps
module can_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_pending,
   input logic       busy,
   input logic [2:0] mode_status,
   input logic       cfg_lock,
   input logic       ecnt_clr,
   input logic       wake_flag,
   input logic       wake_irq,
   input logic       tx_pin,
   input logic       tx_en,
   input logic       rx_en
);
   assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pending && mode_status != 3'b001) |=> $stable(mode_status));

   assert_cfg_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'b100 && $past(mode_status) != 3'b100)
         |-> (!$past(busy) || $past(mode_status) == 3'b001));

   assert_clr_in_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt_clr |-> (mode_status == 3'b100 && cfg_lock));

   assert_pin_recessive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status != 3'b000 && $past(mode_status) != 3'b000) |-> tx_pin);

   assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'b001) |-> (!tx_en && !rx_en));

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> wake_flag);

   assert_wake_leaves_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> ($past(mode_status) == 3'b001 && mode_status != 3'b001));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending), .busy(busy),
   .mode_status(mode_status), .cfg_lock(cfg_lock), .ecnt_clr(ecnt_clr),
   .wake_flag(wake_flag), .wake_irq(wake_irq), .tx_pin(tx_pin),
   .tx_en(tx_en), .rx_en(rx_en)
);

// File: tb/can_mode_seq_bench.sv
`timescale 1ns/1ps
module can_mode_seq_bench;
   localparam int CLK_NS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] req = 3'b100;
   logic er = 0, txp = 0, busy = 0, stb = 0, rx = 1, txb = 1;
   logic wen = 0, wie = 0, wclr = 0;
   logic [2:0] mode_status;
   logic cfg_lock, ecnt_clr, wake_flag, wake_irq, tx_pin, rx_core, tx_en, rx_en, ack_en;

   always #(CLK_NS/2) clk = ~clk;

   can_mode_seq u_can_mode_seq (
      .clk(clk), .rst_n(rst_n), .req_mode(req), .errrec_req(er), .tx_pending(txp),
      .busy(busy), .bit_strobe(stb), .rx_pin(rx), .tx_bit(txb), .wake_en(wen),
      .wake_ie(wie), .wake_clr(wclr), .mode_status(mode_status), .cfg_lock(cfg_lock),
      .ecnt_clr(ecnt_clr), .wake_flag(wake_flag), .wake_irq(wake_irq), .tx_pin(tx_pin),
      .rx_core(rx_core), .tx_en(tx_en), .rx_en(rx_en), .ack_en(ack_en)
   );

   typedef struct {
      logic [11:0] v;
      string       tag;
   } item_t;
   item_t sb[$];

   int checks = 0, fails = 0;
   bit done = 0;
   logic [2:0] em = 3'b100;
   logic eclr = 0, eflag = 0, edisc = 0;

   // {status, lock, clr, flag, irq, txpin, txen, rxen, acken, rxcore}
   function automatic logic [11:0] expv();
      logic lock, tp, te, re, ae, rc;
      lock = (em == 3'b100);
      tp = 1; te = 0; re = 0; ae = 0; rc = rx;
      case (em)
         3'b000: begin tp = txb; te = 1; re = !edisc; ae = 1; end
         3'b011, 3'b111: re = !edisc;
         3'b010: begin te = 1; re = !edisc; rc = txb; end
         default: ;
      endcase
      return {em, lock, eclr, eflag, eflag & wie, tp, te, re, ae, rc};
   endfunction

   task automatic cyc(input string tag);
      item_t it;
      it.v = expv();
      it.tag = tag;
      sb.push_back(it);
      eclr = 0;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            logic [11:0] got;
            it = sb.pop_front();
            got = {mode_status, cfg_lock, ecnt_clr, wake_flag, wake_irq,
                   tx_pin, tx_en, rx_en, ack_en, rx_core};
            checks++;
            if (got !== it.v) begin
               fails++;
               $display("FAIL %s got %b expected %b", it.tag, got, it.v);
            end
         end
      end
   end

   initial begin
      #(CLK_NS * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc("R1");                                   // reset state
      req = 3'b000; em = 3'b000; cyc("R2");        // normal
      txb = 0; cyc("R10"); txb = 1; cyc("R10");
      req = 3'b011; txp = 1; cyc("R3"); cyc("R3"); // held by pending
      txp = 0; em = 3'b011; cyc("R11");            // listen-only
      req = 3'b000; er = 1; em = 3'b111; cyc("R2");// error recognition
      txb = 0; cyc("R11"); txb = 1;
      req = 3'b010; er = 0; em = 3'b010; cyc("R12");
      txb = 0; cyc("R12"); txb = 1; cyc("R12");
      req = 3'b101; busy = 1; cyc("R4"); cyc("R4");
      busy = 0; em = 3'b100; eclr = 1; cyc("R5");
      cyc("R5");                                   // clear was one cycle
      req = 3'b000; em = 3'b000; cyc("R2");
      // sleep while busy: needs 11 recessive bits in a row
      stb = 1; rx = 0; cyc("R6");
      rx = 1; req = 3'b001; busy = 1;
      repeat (5) cyc("R6");
      rx = 0; cyc("R6"); rx = 1;                   // dominant restarts count
      repeat (11) cyc("R6");
      em = 3'b001; cyc("R6");
      stb = 0; busy = 0;
      txb = 0; cyc("R7"); txb = 1; cyc("R7");
      // wake disabled: no effect
      rx = 0; cyc("R8"); rx = 1; cyc("R8");
      // wake enabled
      wen = 1; rx = 0; em = 3'b000; eflag = 1; edisc = 1; cyc("R8");
      rx = 1; cyc("R9"); cyc("R9");                // no re-entry into sleep
      wie = 1; cyc("R8");
      stb = 1;
      repeat (11) cyc("R9");
      edisc = 0; cyc("R9");
      stb = 0;
      // configuration leaves the flag alone
      req = 3'b100; em = 3'b100; eclr = 1; cyc("R5");
      wclr = 1; eflag = 0; cyc("R13"); wclr = 0; cyc("R13");
      // sleep from configuration, wake back into configuration
      req = 3'b001; em = 3'b001; cyc("R6");
      rx = 0; em = 3'b100; eclr = 1; eflag = 1; edisc = 1; cyc("R8");
      rx = 1; cyc("R9");
      @(posedge clk);
      #2;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule